// File: doc/BRIEF.md
# Read/Write Memory Port Arbiter

This block shares one single-port memory between two request streams: a write stream coming from the receive side and a read stream coming from the transmit side. Each cycle at most one request is granted. Priority between the two streams is held in a single bit. That bit changes only in a cycle where a write and an eligible read are offered together, so the winner of one collision loses the next one. Cycles without a collision leave the priority unchanged.

For every granted access the block works out the byte enables from the two low address bits and the access size. Write data arrives right-justified, and the block shifts it onto the addressed byte lanes of the 32-bit memory bus. The memory answers a read exactly one cycle after the request. The block captures that word, shifts it back down to bit 0, masks it to the access size, and returns it on a response port. The response carries the tag that came with the read.

A request with a misaligned address or a reserved size code is consumed without touching the memory. For a write, the block raises an error pulse. For a read, it returns a response with an error flag and zero data. Only one read may be in flight, and the response register holds its contents until the consumer takes them.

Top module: `mem_port_arbiter`

## Requirements
- R1: After reset, rsp_valid is low and the read side holds priority: when a write and an eligible read are offered together in the first cycle, the read is granted.
- R2: At most one of wr_ready and rd_ready is high in a cycle. A write is granted only when no eligible read is offered, or when the write side holds priority. A request that is offered alone is granted at once, provided it is eligible.
- R3: The priority bit flips in each cycle where a write and an eligible read collide, and it keeps its value in every other cycle.
- R4: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. The byte enables are 4'b0001 shifted left by addr[1:0] for code 0, 4'b0011 shifted left by addr[1:0] for code 1, and 4'b1111 for code 2.
- R5: On a granted write, mem_wdata equals wr_data shifted left by 8*addr[1:0] bits.
- R6: mem_addr equals the request address with bits [1:0] cleared. mem_we is 1 for a write and 0 for a read.
- R7: A request is erroneous when its size code is 3, when code 1 is used with addr[0]=1, or when code 2 is used with addr[1:0] not equal to 0. Such a request is accepted but issues no memory access. A write raises wr_err in its accept cycle. A read returns rsp_err=1 with rsp_data=0.
- R8: A read accepted in cycle t produces rsp_valid in cycle t+2. In that response, rsp_data is the memory word shifted right by 8*addr[1:0] and zero-extended above the access size, and rsp_tag equals the request tag.
- R9: rd_ready stays low while a read is in flight, and also while an unconsumed response is held. While rsp_valid is high and rsp_ready is low, rsp_data, rsp_tag and rsp_err stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Right-justified write data |
| wr_err | output | 1 | Accepted write was misaligned or of reserved size |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | ADDR_W | Read byte address |
| rd_size | input | 2 | Read size code |
| rd_tag | input | TAG_W | Requester tag |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Realigned read data |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_err | output | 1 | Answered read was erroneous |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |

## Verification
The assertions check the following on every cycle:
- the two grants never coincide;
- a side that wins a collision cannot win the collision in the following cycle;
- every memory access carries 1, 2 or 4 byte enables;
- an erroneous request never reaches the memory;
- a read access is always followed by a pending capture;
- a stalled response holds still.

Some behaviours can only be shown by the bench scenarios, because they depend on values the bench computes itself:
- the exact byte-enable pattern and lane position for each address and size;
- the realigned and masked read value;
- the arrival of the response exactly two cycles after acceptance;
- the read, write, write, read grant pattern under continuous contention.

// File: rtl/mem_arb_pkg.sv
// Package: shared size encoding and helper functions for the memory port
// arbiter. Assumes a 32-bit data bus with four byte lanes.
package mem_arb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // True when the size code is legal and the low address bits suit it.
    function automatic logic size_ok(input logic [1:0] size, input logic [1:0] off);
        case (acc_size_e'(size))
            SZ_BYTE: size_ok = 1'b1;
            SZ_HALF: size_ok = (off[0] == 1'b0);
            SZ_WORD: size_ok = (off == 2'b00);
            default: size_ok = 1'b0;
        endcase
    endfunction

    // Number of bytes covered by a size code (0 for the reserved code).
    function automatic int unsigned size_bytes(input logic [1:0] size);
        case (acc_size_e'(size))
            SZ_BYTE: size_bytes = 1;
            SZ_HALF: size_bytes = 2;
            SZ_WORD: size_bytes = 4;
            default: size_bytes = 0;
        endcase
    endfunction

endpackage

// File: rtl/mem_arb_prio.sv
// Module: two-way grant logic with a single priority bit.
// The priority bit changes only when both sides ask in the same cycle.
// Assumes rd_valid has already been qualified by the read slot being free.
module mem_arb_prio (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic rd_valid,
    output logic wr_go,
    output logic rd_go,
    output logic prio_wr
);

    logic clash;

    // Grant decision from requests and current priority.
    always_comb begin
        clash = wr_valid && rd_valid;
        wr_go = wr_valid && (!rd_valid || prio_wr);
        rd_go = rd_valid && (!wr_valid || !prio_wr);
    end

    // Priority bit: reads first after reset, toggled by each clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_wr <= 1'b0;
        end else if (clash) begin
            prio_wr <= !prio_wr;
        end
    end

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && rd_go));

    // R3
    wr_no_repeat_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_valid && wr_go) |=> !(wr_valid && rd_valid && wr_go));

    // R3
    rd_no_repeat_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_valid && rd_go) |=> !(wr_valid && rd_valid && rd_go));

endmodule

// File: rtl/mem_lane_steer.sv
// Module: byte-enable generation, alignment check and write-lane steering
// for one request. Purely combinational.
// Assumes DATA_W is 32 (four lanes); sizes wider than the bus are not used.
module mem_lane_steer
    import mem_arb_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] data_in,
    output logic              aligned,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lanes
);

    // Alignment and lane mask from the offset and size code.
    always_comb begin
        aligned = size_ok(size, off);
        be      = '0;
        for (int i = 0; i < LANES; i++) begin
            if ((i >= int'(off)) && (i < int'(off) + int'(size_bytes(size)))) begin
                be[i] = aligned;
            end
        end
    end

    // Shift right-justified data up to the addressed lanes.
    always_comb begin
        lanes = data_in << {off, 3'b000};
    end

endmodule

// File: rtl/mem_rd_return.sv
// Module: read response path. Tracks the single in-flight read, captures
// the memory word one cycle after the request, realigns it to bit 0 and
// holds it until the consumer accepts it.
// Assumes the memory returns data exactly one cycle after a read request.
module mem_rd_return
    import mem_arb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_err,
    input  logic [OFF_W-1:0]  issue_off,
    input  logic [1:0]        issue_size,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              rsp_ready,
    output logic              slot_free,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_err
);

    logic              pend_q;
    logic              pend_err_q;
    logic [OFF_W-1:0]  pend_off_q;
    logic [1:0]        pend_size_q;
    logic [TAG_W-1:0]  pend_tag_q;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] size_mask;

    // A new read may start when nothing is in flight and the output slot empties.
    always_comb begin
        slot_free = !pend_q && (!rsp_valid || rsp_ready);
    end

    // Realign the returned word and clear bytes beyond the access size.
    always_comb begin
        shifted   = mem_rdata >> {pend_off_q, 3'b000};
        size_mask = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(size_bytes(pend_size_q))) begin
                size_mask[i*8 +: 8] = 8'hFF;
            end
        end
    end

    // In-flight read bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_err_q  <= 1'b0;
            pend_off_q  <= '0;
            pend_size_q <= '0;
            pend_tag_q  <= '0;
        end else begin
            pend_q <= issue;
            if (issue) begin
                pend_err_q  <= issue_err;
                pend_off_q  <= issue_off;
                pend_size_q <= issue_size;
                pend_tag_q  <= issue_tag;
            end
        end
    end

    // Response holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_tag   <= '0;
            rsp_err   <= 1'b0;
        end else if (pend_q) begin
            rsp_valid <= 1'b1;
            rsp_data  <= pend_err_q ? '0 : (shifted & size_mask);
            rsp_tag   <= pend_tag_q;
            rsp_err   <= pend_err_q;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !rsp_valid);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_data) && $stable(rsp_tag) && $stable(rsp_err)));

    // R8
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> rsp_valid);

endmodule

// File: rtl/mem_port_arbiter.sv
// Module: top of the memory port arbiter. Grants one of a write stream and
// a read stream per cycle, drives the single-port memory and returns the
// realigned read data with its tag.
// Assumes the memory always accepts a request and answers reads one cycle later.
module mem_port_arbiter
    import mem_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 4,
    localparam int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              slot_free;
    logic              rd_eligible;
    logic              wr_go;
    logic              rd_go;
    logic              prio_wr;
    logic              wr_aligned;
    logic              rd_aligned;
    logic [LANES-1:0]  wr_be;
    logic [LANES-1:0]  rd_be;
    logic [DATA_W-1:0] wr_lanes;
    logic [DATA_W-1:0] rd_lanes_unused;

    // A read competes only when the response path can take it.
    always_comb begin
        rd_eligible = rd_valid && slot_free;
    end

    mem_arb_prio u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .rd_valid (rd_eligible),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .prio_wr  (prio_wr)
    );

    mem_lane_steer #(.DATA_W(DATA_W)) u_wr_steer (
        .off     (wr_addr[OFF_W-1:0]),
        .size    (wr_size),
        .data_in (wr_data),
        .aligned (wr_aligned),
        .be      (wr_be),
        .lanes   (wr_lanes)
    );

    mem_lane_steer #(.DATA_W(DATA_W)) u_rd_steer (
        .off     (rd_addr[OFF_W-1:0]),
        .size    (rd_size),
        .data_in ('0),
        .aligned (rd_aligned),
        .be      (rd_be),
        .lanes   (rd_lanes_unused)
    );

    mem_rd_return #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (rd_go),
        .issue_err  (!rd_aligned),
        .issue_off  (rd_addr[OFF_W-1:0]),
        .issue_size (rd_size),
        .issue_tag  (rd_tag),
        .mem_rdata  (mem_rdata),
        .rsp_ready  (rsp_ready),
        .slot_free  (slot_free),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_tag    (rsp_tag),
        .rsp_err    (rsp_err)
    );

    // Handshake outputs and write error pulse.
    always_comb begin
        wr_ready = wr_go;
        rd_ready = rd_go;
        wr_err   = wr_go && !wr_aligned;
    end

    // Memory port drive: the granted side's word address, enables and data.
    always_comb begin
        mem_req   = (wr_go && wr_aligned) || (rd_go && rd_aligned);
        mem_we    = wr_go;
        mem_addr  = wr_go ? wr_addr : rd_addr;
        mem_addr[OFF_W-1:0] = '0;
        mem_be    = wr_go ? wr_be : rd_be;
        mem_wdata = wr_go ? wr_lanes : '0;
    end

    // R4
    be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) inside {1, 2, 4}));

    // R7
    wr_err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> !mem_req);

    // R8
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !rd_ready);

    // R2
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready |-> wr_valid) and (rd_ready |-> rd_valid));

endmodule

// File: tb/mem_port_arbiter_tb.sv
module mem_port_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [15:0] rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic [3:0]  rd_tag = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_data;
    logic [3:0]  rsp_tag;
    logic        rsp_err;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    logic [31:0] mem [16];

    always #10 clk = ~clk;

    mem_port_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_tag(rd_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .rsp_err(rsp_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: byte-enabled writes, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else if (mem_req) begin
            mem_rdata <= mem[mem_addr[5:2]];
        end
    end

    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] lanes;
        logic        err;
    } wvec_t;

    localparam wvec_t WV [9] = '{
        '{16'h0010, 2'd0, 32'h000000AB, 4'b0001, 32'h000000AB, 1'b0},
        '{16'h0013, 2'd0, 32'h000000CD, 4'b1000, 32'hCD000000, 1'b0},
        '{16'h0011, 2'd0, 32'h00000077, 4'b0010, 32'h00007700, 1'b0},
        '{16'h0022, 2'd1, 32'h00001234, 4'b1100, 32'h12340000, 1'b0},
        '{16'h0020, 2'd1, 32'h0000BEEF, 4'b0011, 32'h0000BEEF, 1'b0},
        '{16'h0030, 2'd2, 32'hDEADBEEF, 4'b1111, 32'hDEADBEEF, 1'b0},
        '{16'h0031, 2'd1, 32'h00005555, 4'b0000, 32'h00000000, 1'b1},
        '{16'h0032, 2'd2, 32'h66666666, 4'b0000, 32'h00000000, 1'b1},
        '{16'h0034, 2'd3, 32'h77777777, 4'b0000, 32'h00000000, 1'b1}
    };

    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  size;
        logic [3:0]  tag;
        logic [31:0] exp;
        logic        err;
    } rvec_t;

    localparam rvec_t RV [6] = '{
        '{16'h0013, 2'd0, 4'h3, 32'h000000CD, 1'b0},
        '{16'h0011, 2'd0, 4'h9, 32'h00000077, 1'b0},
        '{16'h0010, 2'd1, 4'h1, 32'h000077AB, 1'b0},
        '{16'h0022, 2'd1, 4'hA, 32'h00001234, 1'b0},
        '{16'h0030, 2'd2, 4'hF, 32'hDEADBEEF, 1'b0},
        '{16'h0021, 2'd1, 4'h6, 32'h00000000, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    // Offer one read alone, then check the response two cycles after acceptance.
    task automatic do_read(input rvec_t v);
        rd_valid = 1'b1; rd_addr = v.addr; rd_size = v.size; rd_tag = v.tag;
        #2;
        while (!rd_ready) settle();
        chk("R6 read we", {31'd0, mem_we}, 32'd0);
        chk("R7 read access", {31'd0, mem_req}, {31'd0, !v.err});
        @(negedge clk);
        rd_valid = 1'b0;
        settle();
        chk("R8 rsp_valid at t+2", {31'd0, rsp_valid}, 32'd1);
        chk("R8 rsp_data", rsp_data, v.exp);
        chk("R8 rsp_tag", {28'd0, rsp_tag}, {28'd0, v.tag});
        chk("R7 rsp_err", {31'd0, rsp_err}, {31'd0, v.err});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] pat [4];
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

        // Write vector table walked with the read side idle.
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_addr = WV[i].addr; wr_size = WV[i].size; wr_data = WV[i].data;
            #2;
            chk("R2 lone write granted", {31'd0, wr_ready}, 32'd1);
            chk("R7 write error flag", {31'd0, wr_err}, {31'd0, WV[i].err});
            chk("R7 write access", {31'd0, mem_req}, {31'd0, !WV[i].err});
            chk("R6 write we", {31'd0, mem_we}, 32'd1);
            chk("R6 word address", {16'd0, mem_addr}, {16'd0, WV[i].addr & 16'hFFFC});
            if (!WV[i].err) begin
                chk("R4 byte enables", {28'd0, mem_be}, {28'd0, WV[i].be});
                chk("R5 steered lanes", mem_wdata & {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}},
                    WV[i].lanes);
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;

        // Read vector table.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            do_read(RV[i]);
        end

        // Reset, then continuous contention: expect read, write, write, read.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr_valid = 1'b1; wr_addr = 16'h003C; wr_size = 2'd2; wr_data = 32'h11111111;
        rd_valid = 1'b1; rd_addr = 16'h003C; rd_size = 2'd2; rd_tag = 4'h2;
        rsp_ready = 1'b1;
        #2;
        for (int c = 0; c < 4; c++) begin
            pat[c] = {rd_ready, wr_ready};
            settle();
        end
        chk("R1 read wins first clash", {30'd0, pat[0]}, 32'b10);
        chk("R2 write while read in flight", {30'd0, pat[1]}, 32'b01);
        chk("R3 write wins after flip", {30'd0, pat[2]}, 32'b01);
        chk("R3 read wins after second flip", {30'd0, pat[3]}, 32'b10);
        wr_valid = 1'b0;
        rd_valid = 1'b0;
        repeat (3) @(negedge clk);

        // Stalled response: data held, further reads blocked.
        rsp_ready = 1'b0;
        rd_valid = 1'b1; rd_addr = 16'h0030; rd_size = 2'd2; rd_tag = 4'h5;
        #2;
        while (!rd_ready) settle();
        @(negedge clk);
        rd_addr = 16'h0010; rd_size = 2'd0; rd_tag = 4'h7;
        #2;
        chk("R9 no accept while in flight", {31'd0, rd_ready}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            settle();
            chk("R9 held valid", {31'd0, rsp_valid}, 32'd1);
            chk("R9 held data", rsp_data, 32'hDEADBEEF);
            chk("R9 held tag", {28'd0, rsp_tag}, 32'd5);
            chk("R9 blocked while full", {31'd0, rd_ready}, 32'd0);
        end
        @(negedge clk);
        rsp_ready = 1'b1;
        #2;
        chk("R9 accept as slot drains", {31'd0, rd_ready}, 32'd1);
        @(negedge clk);
        rd_valid = 1'b0;
        settle();
        chk("R8 next response data", rsp_data, 32'h000000AB);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule